// File: doc/BRIEF.md
# Shift-Clock Loss Watchdog

This block watches the serial shift clock of a driver chip from a free-running reference clock. The shift clock arrives asynchronously and passes through a short synchronizer chain. Each rising edge that comes out of that chain restarts a timeout counter. The counter runs only while the watchdog enable bit from the control word is set. If the counter reaches its limit before the next edge, the watchdog trips. A trip raises a global force-off line that turns every driver output off, and sets a sticky watchdog status bit that is read out in the status word.

A thermal-fault flag from the temperature sensor feeds the same force-off line. It has its own status bit. That bit follows the synchronized flag, so it clears on its own once the fault goes away.

The watchdog status bit is cleared in two steps, and only after both:
- a control-word transfer (`ctl_load`) has been seen while the bit is set;
- a later shift-clock edge shows that shifting has resumed.

The timeout limit is a count of reference cycles. Its default of 25000 cycles equals 100 µs at a 250 MHz reference clock. This sits between the bound below which the watchdog must never trip (25 µs) and the bound beyond which it must trip (200 µs).

Top module: `shift_clock_watchdog`

## Requirements
- R1: While reset is asserted and right after it is released, `force_off`, `wd_status` and `therm_status` are all 0.
- R2: A rising edge on `shift_clk` restarts the timeout. While enabled, rising edges spaced at most TIMEOUT_CYC reference cycles apart never set `wd_status`.
- R3: While enabled and with no further rising edge, `wd_status` becomes 1 exactly TIMEOUT_CYC+SYNC_STAGES+2 reference rising edges after `shift_clk` rises (counted from the first reference edge that samples the high level). It is still 0 one edge earlier. A falling edge of `shift_clk` does not restart the timeout when BOTH_EDGES is 0.
- R4: While `wd_enable` is 0, the counter is held at zero and no trip occurs. When `wd_enable` rises with no shift activity, `wd_status` becomes 1 exactly TIMEOUT_CYC+1 reference edges later.
- R5: Once set, `wd_status` stays 1 when `wd_enable` drops and when shift-clock edges arrive without a prior control-word transfer.
- R6: After a one-cycle `ctl_load` pulse while `wd_status` is 1, the bit stays 1 until a `shift_clk` rising edge is seen. It then reads 0 exactly SYNC_STAGES+1 reference edges after that rise. A `ctl_load` pulse on its own does not clear the bit.
- R7: `therm_status` equals the level of `therm_fault` delayed by exactly SYNC_STAGES+1 reference edges, for both setting and clearing.
- R8: `force_off` is 1 exactly when `wd_status` or `therm_status` is 1.
- R9: When a watchdog clear and the onset of a thermal fault land on the same reference edge, `force_off` stays 1 across that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Serial shift clock, asynchronous to clk_ref |
| wd_enable | input | 1 | Watchdog enable bit from the control word (clk_ref domain) |
| ctl_load | input | 1 | One-cycle pulse on each control-word transfer (clk_ref domain) |
| therm_fault | input | 1 | Over-temperature flag, asynchronous |
| force_off | output | 1 | Turns all driver outputs off |
| wd_status | output | 1 | Sticky watchdog trip status |
| therm_status | output | 1 | Thermal shutdown status |

## Verification
Two functions can fall on the same reference edge: the release of a pending watchdog clear, triggered by a resumed shift edge, and the onset of a thermal fault. Both signals pass through synchronizer chains of equal length. The bench therefore raises `shift_clk` and `therm_fault` on the same falling reference edge after a control-word transfer, which puts both status changes on one rising edge. It then checks that the two status bits swap at that edge while `force_off` never drops.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WD_RUN      = 2'd0,
    WD_TRIPPED  = 2'd1,
    WD_CLR_PEND = 2'd2
  } wd_state_e;

  function automatic int unsigned limit_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wdg_edge.sv
module wdg_edge #(
  parameter bit BOTH_EDGES = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic act_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  if (BOTH_EDGES) begin : g_any
    assign act_o = level_i ^ prev_q;
  end else begin : g_rise
    assign act_o = level_i & ~prev_q;

    // a rising-edge pulse can never repeat on the following cycle
    AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      act_o |=> !act_o); // R2
  end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic restart_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = limit_width(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q == LIMIT);

  // counter saturates at the limit and never wraps
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R3

endmodule

// File: rtl/wdg_status.sv
module wdg_status
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic expired_i,
  input  logic act_i,
  input  logic load_i,
  input  logic therm_i,
  output logic wd_o,
  output logic therm_o
);

  wd_state_e state_q, state_d;
  logic      therm_q;
  logic      trip;

  assign trip = enable_i & expired_i & ~act_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_RUN:      if (trip)   state_d = WD_TRIPPED;
      WD_TRIPPED:  if (load_i) state_d = WD_CLR_PEND;
      WD_CLR_PEND: if (act_i)  state_d = WD_RUN;
      default:                 state_d = WD_TRIPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_RUN;
      therm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      therm_q <= therm_i;
    end
  end

  assign wd_o    = (state_q != WD_RUN);
  assign therm_o = therm_q;

  AST_TRIP_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_o) |-> $past(expired_i)); // R3
  AST_TRIP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_o) |-> $past(enable_i)); // R4
  AST_CLEAR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_o) |-> $past(act_i)); // R6

endmodule

// File: rtl/shift_clock_watchdog.sv
module shift_clock_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 25000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          BOTH_EDGES  = 1'b0
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic shift_clk,
  input  logic wd_enable,
  input  logic ctl_load,
  input  logic therm_fault,
  output logic force_off,
  output logic wd_status,
  output logic therm_status
);

  logic sclk_sync;
  logic therm_sync;
  logic act;
  logic expired;

  wdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_i   (shift_clk),
    .q_o   (sclk_sync)
  );

  wdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_therm_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_i   (therm_fault),
    .q_o   (therm_sync)
  );

  wdg_edge #(.BOTH_EDGES(BOTH_EDGES)) u_edge (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .level_i (sclk_sync),
    .act_o   (act)
  );

  wdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .enable_i  (wd_enable),
    .restart_i (act),
    .expired_o (expired)
  );

  wdg_status u_status (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .enable_i  (wd_enable),
    .expired_i (expired),
    .act_i     (act),
    .load_i    (ctl_load),
    .therm_i   (therm_sync),
    .wd_o      (wd_status),
    .therm_o   (therm_status)
  );

  assign force_off = wd_status | therm_status;

  // an observed edge never leads straight into a trip
  AST_NO_TRIP_AFTER_EDGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act && !wd_status) |=> !wd_status); // R2

endmodule

// File: tb/tb_shift_clock_watchdog.sv
module tb_shift_clock_watchdog;

  localparam int unsigned T = 300;
  localparam int unsigned S = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic shift_clk, wd_enable, ctl_load, therm_fault;
  logic force_off, wd_status, therm_status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shift_clock_watchdog #(.TIMEOUT_CYC(T), .SYNC_STAGES(S), .BOTH_EDGES(1'b0)) dut (
    .clk_ref      (clk),
    .rst_n        (rst_n),
    .shift_clk    (shift_clk),
    .wd_enable    (wd_enable),
    .ctl_load     (ctl_load),
    .therm_fault  (therm_fault),
    .force_off    (force_off),
    .wd_status    (wd_status),
    .therm_status (therm_status)
  );

  function automatic logic exp_force(logic wd, logic th);
    return wd | th;
  endfunction

  function automatic int unsigned trip_delay();
    return T + S + 2;
  endfunction

  task automatic chk(string tag, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, actual, expected);
    end
  endtask

  task automatic waitn(int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load();
    ctl_load = 1'b1;
    waitn(1);
    ctl_load = 1'b0;
  endtask

  logic drv [0:127];

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; shift_clk = 1'b0; wd_enable = 1'b0;
    ctl_load = 1'b0; therm_fault = 1'b0;
    waitn(5);
    chk("R1 force_off in reset", force_off, 1'b0);
    chk("R1 wd_status in reset", wd_status, 1'b0);
    chk("R1 therm_status in reset", therm_status, 1'b0);
    rst_n = 1'b1;
    waitn(2);
    chk("R1 wd_status after reset", wd_status, 1'b0);

    // R4: disabled means no trip even with no activity
    waitn(3 * T);
    chk("R4 disabled no trip", wd_status, 1'b0);
    wd_enable = 1'b1;
    waitn(T);
    chk("R4 enable window not yet", wd_status, 1'b0);
    waitn(1);
    chk("R4 enable window trip", wd_status, 1'b1);
    chk("R8 force_off on trip", force_off, exp_force(wd_status, therm_status));

    // R5: sticky through disable and stray edges
    wd_enable = 1'b0;
    waitn(5);
    chk("R5 sticky after disable", wd_status, 1'b1);
    for (int i = 0; i < 4; i++) begin
      shift_clk = 1'b1; waitn(3);
      shift_clk = 1'b0; waitn(3);
    end
    chk("R5 sticky after edges", wd_status, 1'b1);

    // R6: transfer alone does not clear, then a resumed edge does
    pulse_load();
    waitn(10);
    chk("R6 load alone keeps status", wd_status, 1'b1);
    shift_clk = 1'b1;
    waitn(S);
    chk("R6 clear not yet", wd_status, 1'b1);
    waitn(1);
    chk("R6 cleared after edge", wd_status, 1'b0);
    shift_clk = 1'b0;
    waitn(2 * T);
    chk("R4 still disabled no trip", wd_status, 1'b0);

    // R2: random gaps up to the limit never trip
    wd_enable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      int unsigned g, h;
      g = 2 + ($urandom % (T - 1));
      h = 1 + ($urandom % (g - 1));
      shift_clk = 1'b1; waitn(h);
      shift_clk = 1'b0; waitn(g - h);
      chk("R2 no trip with edges", wd_status, 1'b0);
    end
    // R2 directed: gap exactly the limit
    for (int i = 0; i < 3; i++) begin
      shift_clk = 1'b1; waitn(1);
      shift_clk = 1'b0; waitn(T - 1);
    end
    chk("R2 gap at limit no trip", wd_status, 1'b0);

    // R3: exact trip timing after the last rise; fall does not restart
    shift_clk = 1'b1; waitn(1);
    shift_clk = 1'b0;
    waitn(trip_delay() - 2);
    chk("R3 one edge before trip", wd_status, 1'b0);
    waitn(1);
    chk("R3 trip at exact edge", wd_status, 1'b1);

    // R9: clear and thermal onset on the same edge
    pulse_load();
    waitn(3);
    shift_clk = 1'b1; therm_fault = 1'b1;
    for (int i = 0; i < S; i++) begin
      waitn(1);
      chk("R9 force_off held", force_off, 1'b1);
    end
    chk("R7 thermal not yet", therm_status, 1'b0);
    chk("R9 wd before swap", wd_status, 1'b1);
    waitn(1);
    chk("R9 force_off at swap", force_off, 1'b1);
    chk("R9 wd cleared at swap", wd_status, 1'b0);
    chk("R7 thermal set", therm_status, 1'b1);
    shift_clk = 1'b0;
    therm_fault = 1'b0;
    waitn(S);
    chk("R7 thermal clear not yet", therm_status, 1'b1);
    waitn(1);
    chk("R7 thermal cleared", therm_status, 1'b0);
    chk("R8 force_off released", force_off, 1'b0);
    wd_enable = 1'b0;

    // R7/R8: random thermal pattern against a delayed copy
    for (int i = 0; i < 128; i++) begin
      if (i >= S + 1) begin
        chk("R7 thermal follows", therm_status, drv[i - S - 1]);
        chk("R8 force_off follows", force_off, exp_force(wd_status, drv[i - S - 1]));
      end
      drv[i] = ($urandom % 3) == 0;
      therm_fault = drv[i];
      waitn(1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule